// File: doc/BRIEF.md
# Edge Timestamp Channel with Power-State Gating

This block watches one asynchronous input pin and records the value of an external free-running timer at chosen pin transitions. The pin is brought into the clock domain through two flip-flops, and a third flop provides edge detection. A 3-bit mode word selects the transitions of interest: both edges, falling edges, rising edges, or every 4th or every 16th rising edge. Captured timer values go into a small show-ahead FIFO, which the consumer drains with a pop strobe. A 2-bit word sets how many captures make one interrupt. The interrupt flag is sticky, and it is gated by an enable before it leaves the block.

Two power-state inputs limit what the channel does. In sleep, only the interrupt-only mode (`3'b111`) still works. In that mode a rising pin edge raises the flag, nothing is stored, and the channel can request a system wake. In idle, the channel keeps full function unless the stop-in-idle input is set or the timer is stopped. In either of those cases the channel freezes with its counters held.

Top module: `icap_channel`

## Requirements
- R1: After reset the FIFO is empty (`bufNotEmpty`=0), and `irqFlag`, `irqOut`, `ovfFlag` and `wakeOut` are all 0.
- R2: `modeSel` 3'b001 captures on every edge, 3'b010 on every falling edge and 3'b011 on every rising edge. The value stored is `timerVal` at the third rising clock edge after the pin changes.
- R3: `modeSel` 3'b100 captures on every 4th synchronized rising edge, and 3'b101 captures on every 16th. The other rising edges store nothing.
- R4: Outside mode 3'b111, `irqFlag` is set by the (`evtSel`+1)-th capture since the event counter was last cleared. So 2'b00 gives every capture, 2'b01 every 2nd, 2'b10 every 3rd and 2'b11 every 4th.
- R5: `irqFlag` stays set until `irqFlagClr` is pulsed, and a set in the same cycle wins. `irqOut` is high exactly when `irqFlag` and `irqEn` are both high.
- R6: The FIFO holds 4 entries, oldest first at `capData`, and `popReq` removes the head. A capture into a full FIFO is discarded and sets `ovfFlag`. `ovfFlag` holds until `ovfClr` is pulsed.
- R7: While `sleepIn` is high, the capture modes (3'b001 to 3'b101) store nothing, count nothing and set no flag.
- R8: In mode 3'b111, every rising pin edge sets `irqFlag` whatever `evtSel` is, and stores no timer value. If `irqEn` is high and `sleepIn` or `idleIn` is high, the same edge sets `wakeOut`. This holds even when the timer is stopped. `wakeOut` clears together with the flag on `irqFlagClr`.
- R9: While `idleIn` is high and either `stopInIdle` is high or `timerOn` is low, the capture modes freeze. Edges are ignored, and the prescale and event counts hold their values until the freeze ends. With `stopInIdle` low and `timerOn` high, idle does not change behaviour.
- R10: `modeSel` 3'b000 and 3'b110 disable the channel. No capture takes place and no flag is set.
- R11: Any change of `modeSel` clears the prescale count and the event count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pinIn | input | 1 | Asynchronous pin to timestamp |
| timerVal | input | TW | Free-running timer value to latch |
| timerOn | input | 1 | Timer is running |
| modeSel | input | 3 | Edge / prescale / interrupt-only mode |
| evtSel | input | 2 | Captures per interrupt minus one |
| stopInIdle | input | 1 | Freeze the channel in idle |
| sleepIn | input | 1 | System is in sleep |
| idleIn | input | 1 | System is in idle |
| irqEn | input | 1 | Interrupt enable |
| irqFlagClr | input | 1 | Clear interrupt flag and wake request |
| popReq | input | 1 | Remove the FIFO head |
| ovfClr | input | 1 | Clear overflow flag |
| capData | output | TW | FIFO head value |
| bufNotEmpty | output | 1 | FIFO holds at least one value |
| ovfFlag | output | 1 | Sticky overflow indication |
| irqFlag | output | 1 | Sticky interrupt flag |
| irqOut | output | 1 | Gated interrupt request |
| wakeOut | output | 1 | Wake request |

## Verification
The properties assume that `irqFlagClr` and `ovfClr` are single-cycle pulses, and that `sleepIn` and `idleIn` are set from the clock domain. The bench holds each pin level for four clocks, so every transition passes the synchronizer. It holds `timerVal` constant from the pin change through the capture edge. It changes `modeSel`, `evtSel` and the power inputs only when the pin is quiet and at least three clocks before the next pin edge. That keeps any mode change from landing inside the latency of an edge.

// File: rtl/icap_pkg.sv
package icap_pkg;
  typedef enum logic [2:0] {
    MODE_OFF     = 3'b000,
    MODE_BOTH    = 3'b001,
    MODE_FALL    = 3'b010,
    MODE_RISE    = 3'b011,
    MODE_DIV4    = 3'b100,
    MODE_DIV16   = 3'b101,
    MODE_RSVD    = 3'b110,
    MODE_IRQONLY = 3'b111
  } mode_e;

  typedef struct packed {
    logic capWr;
    logic irqSet;
    logic wakeSet;
  } strobe_t;
endpackage

// File: rtl/icap_ctrl.sv
module icap_ctrl
  import icap_pkg::*;
#(
  parameter int PRE_FAST = 4,
  parameter int PRE_SLOW = 16,
  parameter int SYNC_LEN = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       pinIn,
  input  logic [2:0] modeSel,
  input  logic [1:0] evtSel,
  input  logic       stopInIdle,
  input  logic       sleepIn,
  input  logic       idleIn,
  input  logic       timerOn,
  input  logic       irqEn,
  output strobe_t    strb
);
  localparam int PW = $clog2(PRE_SLOW);

  logic [SYNC_LEN-1:0] syncQ;
  logic                pinPrev;
  logic                pinS, riseEv, fallEv;
  logic [2:0]          modePrev;
  logic                modeChg;
  mode_e               mode;
  logic                frozen, capMode, usePre, edgeHit, preDone, capNow, irqOnlyHit;
  logic [PW-1:0]       preCnt, preLimit;
  logic [1:0]          evtCnt;

  // synchronizer chain plus one history flop for edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ   <= '0;
      pinPrev <= 1'b0;
    end else begin
      syncQ   <= {syncQ[SYNC_LEN-2:0], pinIn};
      pinPrev <= syncQ[SYNC_LEN-1];
    end
  end

  assign pinS   = syncQ[SYNC_LEN-1];
  assign riseEv = pinS & ~pinPrev;
  assign fallEv = ~pinS & pinPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) modePrev <= 3'b000;
    else       modePrev <= modeSel;
  end

  assign modeChg = (modeSel != modePrev);
  assign mode    = mode_e'(modeSel);
  assign frozen  = sleepIn | (idleIn & (stopInIdle | ~timerOn));
  assign capMode = (mode == MODE_BOTH) || (mode == MODE_FALL) || (mode == MODE_RISE) ||
                   (mode == MODE_DIV4) || (mode == MODE_DIV16);
  assign usePre  = (mode == MODE_DIV4) || (mode == MODE_DIV16);

  always_comb begin
    unique case (mode)
      MODE_BOTH:                         edgeHit = riseEv | fallEv;
      MODE_FALL:                         edgeHit = fallEv;
      MODE_RISE, MODE_DIV4, MODE_DIV16:  edgeHit = riseEv;
      default:                           edgeHit = 1'b0;
    endcase
  end

  assign preLimit   = (mode == MODE_DIV16) ? PW'(PRE_SLOW - 1) : PW'(PRE_FAST - 1);
  assign preDone    = ~usePre | (preCnt == preLimit);
  assign capNow     = capMode & ~frozen & edgeHit & preDone;
  assign irqOnlyHit = (mode == MODE_IRQONLY) & riseEv;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt <= '0;
    end else if (modeChg || !capMode) begin
      preCnt <= '0;
    end else if (!frozen && edgeHit && usePre) begin
      preCnt <= preDone ? '0 : preCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      evtCnt <= '0;
    end else if (modeChg || !capMode) begin
      evtCnt <= '0;
    end else if (capNow) begin
      evtCnt <= (evtCnt == evtSel) ? '0 : evtCnt + 1'b1;
    end
  end

  always_comb begin
    strb.capWr   = capNow;
    strb.irqSet  = (capNow & (evtCnt == evtSel)) | irqOnlyHit;
    strb.wakeSet = irqOnlyHit & irqEn & (sleepIn | idleIn);
  end
endmodule

// File: rtl/icap_datapath.sv
module icap_datapath
  import icap_pkg::*;
#(
  parameter int TW    = 16,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  strobe_t       strb,
  input  logic [TW-1:0] timerVal,
  input  logic          popReq,
  input  logic          ovfClr,
  input  logic          irqFlagClr,
  output logic [TW-1:0] capData,
  output logic          bufNotEmpty,
  output logic          ovfFlag,
  output logic          irqFlag,
  output logic          wakeOut
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [TW-1:0] mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;
  logic [CW-1:0] fill;
  logic          full, doPop, doPush;

  assign full   = (fill == CW'(DEPTH));
  assign doPop  = popReq && (fill != '0);
  assign doPush = strb.capWr && (!full || doPop);

  function automatic logic [AW-1:0] nextPtr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= timerVal;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      fill  <= '0;
    end else begin
      if (doPush) wrPtr <= nextPtr(wrPtr);
      if (doPop)  rdPtr <= nextPtr(rdPtr);
      unique case ({doPush, doPop})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ovfFlag <= 1'b0;
      irqFlag <= 1'b0;
      wakeOut <= 1'b0;
    end else begin
      if (strb.capWr && full && !doPop) ovfFlag <= 1'b1;
      else if (ovfClr)                  ovfFlag <= 1'b0;
      if (strb.irqSet)     irqFlag <= 1'b1;
      else if (irqFlagClr) irqFlag <= 1'b0;
      if (strb.wakeSet)    wakeOut <= 1'b1;
      else if (irqFlagClr) wakeOut <= 1'b0;
    end
  end

  assign capData     = mem[rdPtr];
  assign bufNotEmpty = (fill != '0);
endmodule

// File: rtl/icap_channel.sv
module icap_channel
  import icap_pkg::*;
#(
  parameter int TW    = 16,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          pinIn,
  input  logic [TW-1:0] timerVal,
  input  logic          timerOn,
  input  logic [2:0]    modeSel,
  input  logic [1:0]    evtSel,
  input  logic          stopInIdle,
  input  logic          sleepIn,
  input  logic          idleIn,
  input  logic          irqEn,
  input  logic          irqFlagClr,
  input  logic          popReq,
  input  logic          ovfClr,
  output logic [TW-1:0] capData,
  output logic          bufNotEmpty,
  output logic          ovfFlag,
  output logic          irqFlag,
  output logic          irqOut,
  output logic          wakeOut
);
  strobe_t strb;

  icap_ctrl #(.PRE_FAST(4), .PRE_SLOW(16), .SYNC_LEN(2)) u_ctrl (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .modeSel(modeSel), .evtSel(evtSel),
    .stopInIdle(stopInIdle), .sleepIn(sleepIn), .idleIn(idleIn), .timerOn(timerOn),
    .irqEn(irqEn), .strb(strb)
  );

  icap_datapath #(.TW(TW), .DEPTH(DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .timerVal(timerVal), .popReq(popReq),
    .ovfClr(ovfClr), .irqFlagClr(irqFlagClr), .capData(capData),
    .bufNotEmpty(bufNotEmpty), .ovfFlag(ovfFlag), .irqFlag(irqFlag), .wakeOut(wakeOut)
  );

  assign irqOut = irqFlag & irqEn;
endmodule

// File: rtl/icap_channel_chk.sv
module icap_channel_chk (
  input logic       clk,
  input logic       rstN,
  input logic       sleepIn,
  input logic       idleIn,
  input logic       irqEn,
  input logic [2:0] modeSel,
  input logic       bufNotEmpty,
  input logic       ovfFlag,
  input logic       ovfClr,
  input logic       irqFlag,
  input logic       irqOut,
  input logic       wakeOut
);
  // R6: overflow indication is sticky until its clear input
  a_r6_ovf_sticky: assert property (@(posedge clk) disable iff (!rstN)
    ovfFlag && !ovfClr |=> ovfFlag);

  // R6: overflow can only appear while the buffer already holds data
  a_r6_ovf_needs_data: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ovfFlag) |-> $past(bufNotEmpty));

  // R5: the forwarded request never appears without the enable
  a_r5_irq_gated: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> irqEn);

  // R7: no value enters the buffer from an edge seen during sleep
  a_r7_sleep_no_store: assert property (@(posedge clk) disable iff (!rstN)
    $rose(bufNotEmpty) |-> !$past(sleepIn));

  // R8: interrupt-only mode never stores a timer value
  a_r8_irqonly_no_store: assert property (@(posedge clk) disable iff (!rstN)
    $rose(bufNotEmpty) |-> ($past(modeSel) != 3'b111));

  // R8: a wake request needs the enable and a low-power state
  a_r8_wake_cause: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wakeOut) |-> ($past(irqEn) && ($past(sleepIn) || $past(idleIn))));

  // R8: a wake request is always accompanied by the flag
  a_r8_wake_with_flag: assert property (@(posedge clk) disable iff (!rstN)
    wakeOut |-> irqFlag);
endmodule

bind icap_channel icap_channel_chk u_chk (.*);

// File: tb/test_icap_channel.sv
module test_icap_channel;
  localparam int TW = 16;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          pinIn = 1'b0;
  logic [TW-1:0] timerVal = '0;
  logic          timerOn = 1'b1;
  logic [2:0]    modeSel = 3'b000;
  logic [1:0]    evtSel = 2'b00;
  logic          stopInIdle = 1'b0;
  logic          sleepIn = 1'b0;
  logic          idleIn = 1'b0;
  logic          irqEn = 1'b0;
  logic          irqFlagClr = 1'b0;
  logic          popReq = 1'b0;
  logic          ovfClr = 1'b0;
  logic [TW-1:0] capData;
  logic          bufNotEmpty, ovfFlag, irqFlag, irqOut, wakeOut;

  int            checks = 0;
  int            failures = 0;
  logic [TW-1:0] expQ[$];
  logic          drainEn = 1'b1;
  logic          done = 1'b0;
  string         curReq = "R2";
  logic [TW-1:0] stamp = 16'h1000;

  always #10 clk = ~clk;

  icap_channel #(.TW(TW), .DEPTH(4)) i_icap_channel (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .timerVal(timerVal), .timerOn(timerOn),
    .modeSel(modeSel), .evtSel(evtSel), .stopInIdle(stopInIdle), .sleepIn(sleepIn),
    .idleIn(idleIn), .irqEn(irqEn), .irqFlagClr(irqFlagClr), .popReq(popReq),
    .ovfClr(ovfClr), .capData(capData), .bufNotEmpty(bufNotEmpty), .ovfFlag(ovfFlag),
    .irqFlag(irqFlag), .irqOut(irqOut), .wakeOut(wakeOut)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pops the buffer and compares with the scoreboard
  always @(negedge clk) begin
    popReq <= 1'b0;
    if (rstN && drainEn && bufNotEmpty && !popReq) begin
      checks++;
      if (expQ.size() == 0) begin
        failures++;
        $display("FAIL %s actual=%0h expected=none", curReq, capData);
      end else begin
        logic [TW-1:0] e;
        e = expQ.pop_front();
        if (capData !== e) begin
          failures++;
          $display("FAIL %s actual=%0h expected=%0h", curReq, capData, e);
        end
      end
      popReq <= 1'b1;
    end
  end

  // driver: one pin level change with a fresh timer value
  task automatic drivePin(input logic lvl, input logic expCap);
    @(negedge clk);
    stamp    = stamp + 16'h0101;
    timerVal = stamp;
    pinIn    = lvl;
    if (expCap) expQ.push_back(stamp);
    repeat (4) @(negedge clk);
  endtask

  task automatic pulse(input logic capRise, input logic capFall);
    drivePin(1'b1, capRise);
    drivePin(1'b0, capFall);
  endtask

  task automatic setMode(input logic [2:0] m);
    @(negedge clk);
    modeSel = m;
    repeat (3) @(negedge clk);
  endtask

  task automatic clearAll();
    @(negedge clk);
    irqFlagClr = 1'b1;
    ovfClr     = 1'b1;
    @(negedge clk);
    irqFlagClr = 1'b0;
    ovfClr     = 1'b0;
  endtask

  task automatic endScene(input string req);
    @(posedge clk);
    drainEn = 1'b1;
    repeat (12) @(negedge clk);
    chk({req, " queue drained"}, expQ.size(), 0);
    chk({req, " buffer empty"}, bufNotEmpty, 0);
    setMode(3'b000);
    clearAll();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 bufNotEmpty", bufNotEmpty, 0);
    chk("R1 irqFlag", irqFlag, 0);
    chk("R1 irqOut", irqOut, 0);
    chk("R1 ovfFlag", ovfFlag, 0);
    chk("R1 wakeOut", wakeOut, 0);

    // R2 rising, falling, both
    curReq = "R2"; setMode(3'b011);
    pulse(1, 0); pulse(1, 0);
    setMode(3'b010); pulse(0, 1);
    setMode(3'b001); pulse(1, 1);
    endScene("R2");

    // R3 prescaled rising edges
    curReq = "R3"; setMode(3'b100);
    for (int i = 1; i <= 8; i++) pulse(i % 4 == 0, 0);
    setMode(3'b101);
    for (int i = 1; i <= 16; i++) pulse(i == 16, 0);
    endScene("R3");

    // R4 / R5 events per interrupt and gating
    curReq = "R4"; evtSel = 2'b01; irqEn = 1'b0; setMode(3'b011);
    pulse(1, 0);
    chk("R4 no flag after 1st of 2", irqFlag, 0);
    pulse(1, 0);
    chk("R4 flag after 2nd of 2", irqFlag, 1);
    chk("R5 irqOut masked", irqOut, 0);
    @(negedge clk); irqEn = 1'b1; @(negedge clk);
    chk("R5 irqOut enabled", irqOut, 1);
    clearAll();
    chk("R5 flag cleared", irqFlag, 0);
    chk("R5 irqOut after clear", irqOut, 0);
    @(negedge clk); evtSel = 2'b11; setMode(3'b000); setMode(3'b011);
    for (int i = 1; i <= 3; i++) pulse(1, 0);
    chk("R4 no flag after 3rd of 4", irqFlag, 0);
    pulse(1, 0);
    chk("R4 flag after 4th of 4", irqFlag, 1);
    endScene("R4");
    evtSel = 2'b00;

    // R6 overflow
    curReq = "R6"; @(posedge clk); drainEn = 1'b0; setMode(3'b011);
    for (int i = 1; i <= 5; i++) pulse(i <= 4, 0);
    chk("R6 overflow set", ovfFlag, 1);
    repeat (3) @(negedge clk);
    chk("R6 overflow sticky", ovfFlag, 1);
    endScene("R6");
    chk("R6 overflow cleared", ovfFlag, 0);

    // R7 sleep disables capture modes
    curReq = "R7"; setMode(3'b011); @(negedge clk); sleepIn = 1'b1;
    pulse(0, 0);
    chk("R7 no flag in sleep", irqFlag, 0);
    chk("R7 no capture in sleep", bufNotEmpty, 0);
    @(negedge clk); sleepIn = 1'b0;
    pulse(1, 0);
    endScene("R7");

    // R8 interrupt-only mode
    curReq = "R8"; irqEn = 1'b1; evtSel = 2'b11; sleepIn = 1'b1; setMode(3'b111);
    pulse(0, 0);
    chk("R8 flag in sleep", irqFlag, 1);
    chk("R8 wake in sleep", wakeOut, 1);
    chk("R8 no store", bufNotEmpty, 0);
    clearAll();
    chk("R8 wake cleared", wakeOut, 0);
    @(negedge clk); sleepIn = 1'b0; idleIn = 1'b1; stopInIdle = 1'b1; timerOn = 1'b0;
    pulse(0, 0);
    chk("R8 wake in idle timer off", wakeOut, 1);
    clearAll();
    @(negedge clk); idleIn = 1'b0; stopInIdle = 1'b0; timerOn = 1'b1;
    pulse(0, 0);
    chk("R8 flag when running", irqFlag, 1);
    chk("R8 no wake when running", wakeOut, 0);
    @(negedge clk); irqEn = 1'b0; evtSel = 2'b00;
    endScene("R8");

    // R9 idle freeze holds counters
    curReq = "R9"; setMode(3'b100);
    pulse(0, 0); pulse(0, 0);
    @(negedge clk); idleIn = 1'b1; stopInIdle = 1'b1;
    pulse(0, 0); pulse(0, 0); pulse(0, 0);
    chk("R9 frozen no capture", bufNotEmpty, 0);
    @(negedge clk); stopInIdle = 1'b0; timerOn = 1'b0;
    pulse(0, 0);
    @(negedge clk); timerOn = 1'b1;
    pulse(0, 0); pulse(1, 0);
    @(negedge clk); idleIn = 1'b0;
    endScene("R9");

    // R10 disabled encodings
    curReq = "R10"; setMode(3'b110);
    pulse(0, 0);
    chk("R10 reserved no capture", bufNotEmpty, 0);
    chk("R10 reserved no flag", irqFlag, 0);
    setMode(3'b000);
    pulse(0, 0);
    chk("R10 off no capture", bufNotEmpty, 0);
    endScene("R10");

    // R11 mode change clears counters
    curReq = "R11"; setMode(3'b100);
    pulse(0, 0); pulse(0, 0);
    setMode(3'b011); setMode(3'b100);
    pulse(0, 0); pulse(0, 0); pulse(0, 0);
    chk("R11 prescale restarted", bufNotEmpty, 0);
    pulse(1, 0);
    endScene("R11");
    evtSel = 2'b01; setMode(3'b011);
    pulse(1, 0);
    setMode(3'b001); setMode(3'b011);
    pulse(1, 0);
    chk("R11 event count restarted", irqFlag, 0);
    pulse(1, 0);
    chk("R11 flag after restart", irqFlag, 1);
    endScene("R11");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule